// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B, and passes data between them in either direction. Each direction has its own holding register, and each register is loaded by its own clock. A per-direction source select chooses what is driven outward: either the live value on the opposite bus, or the value held in that direction's register. The data path never inverts.

Each bus is modelled as three vectors: an input vector that carries the bus value, an output-data vector, and an output-enable vector. There are no tri-state nets inside the block, so the surrounding logic resolves the real bus. An active-low enable puts the block in isolation, where neither bus is driven. While that enable is asserted, a direction input chooses which single bus is driven. Capture into either register keeps working in every mode, including isolation.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `ab_clk`, the value on `a_in` is loaded into the A-to-B register.
- R2: On each rising edge of `ba_clk`, the value on `b_in` is loaded into the B-to-A register.
- R3: While `oe_n` is 1, `a_oe` and `b_oe` are both all zeros. Both registers still capture on their clock edges in this mode.
- R4: While `oe_n` is 0 and `dir` is 1, `b_oe` is all ones and `a_oe` is all zeros. While `oe_n` is 0 and `dir` is 0, `a_oe` is all ones and `b_oe` is all zeros. The two enables are never both nonzero.
- R5: When `sel_ab` is 0, `b_out` equals `a_in` in the same cycle. When `sel_ba` is 0, `a_out` equals `b_in` in the same cycle. This transparent path adds no clock delay.
- R6: When `sel_ab` is 1, `b_out` equals the A-to-B register. When `sel_ba` is 1, `a_out` equals the B-to-A register. The value is copied bit for bit, without inversion.
- R7: While `rst_n` is 0, both registers are cleared to zero asynchronously.
- R8: While one bus is being driven, edges on either clock, or on both, still load the registers from the input buses.
- R9: A register keeps its value when its input bus changes but its clock has no rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| ab_clk | input | 1 | Load clock of the A-to-B register |
| ba_clk | input | 1 | Load clock of the B-to-A register |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 1 drives bus B from the A side, 0 drives bus A from the B side |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored A-to-B register |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored B-to-A register |
| a_in | input | W | Value present on bus A |
| b_in | input | W | Value present on bus B |
| a_out | output | W | Data to drive onto bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_out | output | W | Data to drive onto bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
The bench builds the block with the default width W of 8. At this width, distinct patterns in every bit position show any bit that is swapped, dropped or inverted in either path. The bench runs through all sixteen combinations of enable, direction and the two selects. For each one it pulses either clock, both clocks or neither. Because the captured value is then driven out through the stored path, register contents are checked only at the ports.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         ab_clk,
  input  logic         ba_clk,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] hold_ab;
  logic [W-1:0] hold_ba;
  logic         drive_a;
  logic         drive_b;

  always_ff @(posedge ab_clk or negedge rst_n) begin
    if (!rst_n) hold_ab <= '0;
    else        hold_ab <= a_in;
  end

  always_ff @(posedge ba_clk or negedge rst_n) begin
    if (!rst_n) hold_ba <= '0;
    else        hold_ba <= b_in;
  end

  assign drive_b = !oe_n &&  dir;
  assign drive_a = !oe_n && !dir;

  assign b_out = sel_ab ? hold_ab : a_in;
  assign a_out = sel_ba ? hold_ba : b_in;
  assign b_oe  = {W{drive_b}};
  assign a_oe  = {W{drive_a}};

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         ab_clk,
  input logic         ba_clk,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] hold_ab,
  input logic [W-1:0] hold_ba
);

  // R1
  ab_load_chk: assert property (@(posedge ab_clk) disable iff (!rst_n)
    1'b1 |=> hold_ab == $past(a_in));

  // R2
  ba_load_chk: assert property (@(posedge ba_clk) disable iff (!rst_n)
    1'b1 |=> hold_ba == $past(b_in));

  always_comb begin
    if (rst_n) begin
      // R4
      one_bus_chk: assert (!((|a_oe) && (|b_oe)));
      // R3
      isolate_chk: assert (!oe_n || (a_oe == '0 && b_oe == '0));
      // R5
      live_b_chk: assert (sel_ab || b_out == a_in);
      // R6
      stored_a_chk: assert (!sel_ba || a_out == hold_ba);
    end
  end

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (
  .rst_n(rst_n), .ab_clk(ab_clk), .ba_clk(ba_clk), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .hold_ab(hold_ab), .hold_ba(hold_ba)
);

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;
  localparam int W = 8;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0, ab_clk = 0, ba_clk = 0;
  logic oe_n = 1, dir = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  regbus_xcvr #(.W(W)) uut (
    .rst_n(rst_n), .ab_clk(ab_clk), .ba_clk(ba_clk), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  int n_run = 0, n_fail = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  // {oe_n, dir, sel_ab, sel_ba, pulse_ab, pulse_ba, a, b}
  localparam logic [21:0] VEC [10] = '{
    {6'b110010, 8'h5A, 8'hC3},
    {6'b110001, 8'h11, 8'h96},
    {6'b111111, 8'hFF, 8'h00},
    {6'b010011, 8'h81, 8'h7E},
    {6'b011000, 8'h01, 8'h80},
    {6'b000111, 8'hA5, 8'h3C},
    {6'b001100, 8'h00, 8'hFF},
    {6'b010000, 8'h24, 8'h42},
    {6'b100000, 8'hE7, 8'h18},
    {6'b000000, 8'h69, 8'h96}
  };

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic verify(input string tag);
    logic [W-1:0] eb_oe, ea_oe;
    eb_oe = (!oe_n &&  dir) ? '1 : '0;
    ea_oe = (!oe_n && !dir) ? '1 : '0;
    check(oe_n ? "R3" : "R4", {tag, " b_oe"}, b_oe, eb_oe);
    check(oe_n ? "R3" : "R4", {tag, " a_oe"}, a_oe, ea_oe);
    check(sel_ab ? "R6" : "R5", {tag, " b_out"}, b_out, sel_ab ? m_ab : a_in);
    check(sel_ba ? "R6" : "R5", {tag, " a_out"}, a_out, sel_ba ? m_ba : b_in);
  endtask

  task automatic step(input logic [5:0] ctl, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string tag);
    @(negedge clk);
    ab_clk = 0; ba_clk = 0;
    {oe_n, dir, sel_ab, sel_ba} = ctl[5:2];
    a_in = a; b_in = b;
    #1;
    verify({tag, " pre"});
    #1;
    if (ctl[1]) begin ab_clk = 1; m_ab = a; end
    if (ctl[0]) begin ba_clk = 1; m_ba = b; end
    #1;
    verify({tag, " post"});
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R7: reset state seen through stored paths
    a_in = 8'hFF; b_in = 8'hFF;
    repeat (2) @(negedge clk);
    ab_clk = 1; ba_clk = 1; #1;
    oe_n = 0; sel_ab = 1; sel_ba = 1; dir = 1; #1;
    check("R7", "b_out in reset", b_out, '0);
    dir = 0; #1;
    check("R7", "a_out in reset", a_out, '0);
    @(negedge clk);
    ab_clk = 0; ba_clk = 0;
    rst_n = 1;

    foreach (VEC[i])
      step(VEC[i][21:16], VEC[i][15:8], VEC[i][7:0], $sformatf("vec%0d", i));

    // every enable/direction/select combination, with mixed capture pulses
    for (int c = 0; c < 16; c++) begin
      step({c[3:0], c[1:0]}, 8'(c * 37 + 5), 8'(~(c * 19)), $sformatf("combo%0d", c));
      step({c[3:0], 2'b00}, 8'(c * 11 + 128), 8'(c * 53), $sformatf("combo%0d hold", c));
    end

    // R3: capture during isolation, then reveal through stored paths
    step(6'b100011, 8'h3C, 8'hC3, "R3 iso cap");
    step(6'b011100, 8'h00, 8'h00, "R3 reveal b");
    check("R3", "isolation A capture", b_out, 8'h3C);
    step(6'b001100, 8'h00, 8'h00, "R3 reveal a");
    check("R3", "isolation B capture", a_out, 8'hC3);

    // R8: both registers capture while bus B is driven live
    step(6'b010011, 8'h96, 8'h69, "R8 cap");
    step(6'b011100, 8'h12, 8'h34, "R8 reveal");
    check("R8", "A reg while driving", b_out, 8'h96);
    step(6'b001100, 8'h12, 8'h34, "R8 reveal a");
    check("R8", "B reg while driving", a_out, 8'h69);

    // R1 / R2 single clocks only touch their own register
    step(6'b011110, 8'hAA, 8'h55, "R1 cap");
    check("R1", "A reg loaded", b_out, 8'hAA);
    step(6'b001100, 8'h00, 8'h00, "R2 chk");
    check("R2", "B reg untouched by ab_clk", a_out, 8'h69);

    // R9: input change without edge leaves the stored value
    step(6'b011100, 8'h0F, 8'hF0, "R9");
    check("R9", "A reg held", b_out, 8'hAA);

    // R5: transparent path follows mid-cycle change with no edge
    step(6'b010000, 8'h77, 8'h00, "R5");
    a_in = 8'h88; #1;
    check("R5", "live follows", b_out, 8'h88);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule